// File: doc/BRIEF.md
# Periodic Interrupt Generator

This block divides a 32768 Hz time base into a programmable periodic interrupt. A one-cycle strobe marks each period of the 32768 Hz clock in the system clock domain. On every strobe a free-running count of those periods advances. Two control registers set the rate: a rate register holds a 4-bit rate code and a mode register holds an enable bit. Together they select a power-of-two period. Ticks never drift with respect to the free-running count. A tick happens exactly when the count reaches a multiple of the selected period, so changing the rate mid-run moves the next tick to the next multiple of the new period.

Each tick sets two flags in a status register and raises the interrupt output. The flags and the interrupt stay set until software reads the status register. The read returns the current flags, and both flags clear on the following clock edge.

Top module: `perirq_gen`

## Requirements
- R1: After reset the interrupt output is low, the status register reads 0x00, the rate code is 0, the enable bit is clear and the period count is zero.
- R2: The period count advances by one on each cycle with `base_tick` high and by nothing otherwise, whatever the settings. A tick is raised only on a strobe, and only when the count after that strobe is a multiple of the selected period.
- R3: The rate code is bits 3:0 of a write with `ctl_sel`=0; bits 7:4 of that write are ignored. For codes 3 to 15 the period is 2^(code-1) strobes.
- R4: Code 1 gives a period of 128 strobes and code 2 gives 256, the same periods as codes 8 and 9.
- R5: With rate code 0, no tick occurs whatever the enable bit holds.
- R6: The enable bit is bit 6 of a write with `ctl_sel`=1; the other bits are ignored. While the bit is clear no tick occurs. A multiple reached while it is clear sets no flag, and is not raised later.
- R7: A tick sets status bits 7 and 6, so the status reads 0xC0, and drives `irq_o` high on the edge of the strobe. The flags then stay set across further strobes until a read.
- R8: A cycle with `stat_rd` high presents the current status on `stat_rdata`. The status then clears and `irq_o` falls on that edge, unless R9 applies.
- R9: When a tick and a read fall on the same edge, the flags end set (0xC0) and `irq_o` stays high.
- R10: A register write takes effect at its clock edge. The first tick after a rate change falls at the next multiple of the new period on the running count, not one full period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle strobe per 32768 Hz period |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_sel | input | 1 | Register select: 0 rate register, 1 mode register |
| ctl_wdata | input | 8 | Control write data |
| stat_rd | input | 1 | Status register read strobe (read clears) |
| stat_rdata | output | 8 | Status register contents |
| irq_o | output | 1 | Interrupt output, high while status bit 7 is set |

## Verification
The bench keeps its own count of strobes from reset and predicts every tick from it. A design that restarts the period at each write, rather than aligning to the global count, fires late after a rate change. A design that decodes codes 1 and 2 literally fires every one or two strobes. The remaining corner cases are a multiple reached while disabled, a read on the same edge as a tick, and ignored register bits. A tick held back and raised on re-enable shows up as a spurious flag. A read that wins the collision loses an interrupt. Decoding a stray bit wrongly enables or mis-rates the timer.

// File: rtl/perirq_pkg.sv
package perirq_pkg;
    localparam int RATE_W       = 4;   // rate code field width
    localparam int EN_BIT       = 6;   // enable bit in the mode register
    localparam int STAT_IRQ_BIT = 7;   // summary interrupt flag
    localparam int STAT_PER_BIT = 6;   // periodic source flag
    localparam int ALIAS_MAX    = 2;   // highest code that aliases to a slow rate
    localparam int ALIAS_OFFSET = 7;   // code + offset gives the aliased code

    typedef enum logic {
        SEL_RATE = 1'b0,
        SEL_MODE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/perirq_ctl.sv
module perirq_ctl
    import perirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [RATE_W-1:0] code_q,
    output logic              en_q
);
    typedef struct packed {
        logic [RATE_W-1:0] code;
        logic              en;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            if (sel == SEL_RATE) begin
                ctl_d.code = wdata[RATE_W-1:0];
            end else begin
                ctl_d.en = wdata[EN_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign code_q = ctl_q.code;
    assign en_q   = ctl_q.en;
endmodule

// File: rtl/perirq_rate_dec.sv
module perirq_rate_dec
    import perirq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic [RATE_W-1:0] code,
    output logic              active,
    output logic [CNT_W-1:0]  mask
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [RATE_W-1:0] eff;
    logic [RATE_W-1:0] shift;

    always_comb begin
        eff = code;
        if ((code != '0) && (code <= RATE_W'(ALIAS_MAX))) begin
            eff = code + RATE_W'(ALIAS_OFFSET);
        end
        shift  = eff - RATE_W'(1);
        active = (code != '0);
        mask   = (ONE << shift) - ONE;
    end
endmodule

// File: rtl/perirq_timebase.sv
module perirq_timebase #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             arm,
    input  logic [CNT_W-1:0] mask,
    output logic             fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_t;

    tb_t tb_d, tb_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        tb_d   = tb_q;
        cnt_nx = tb_q.cnt + CNT_W'(1);
        fire   = 1'b0;
        if (base_tick) begin
            tb_d.cnt = cnt_nx;
            // boundary: low bits of the new count all zero
            fire = arm && ((cnt_nx & mask) == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end
endmodule

// File: rtl/perirq_status.sv
module perirq_status
    import perirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              rd,
    output logic [DATA_W-1:0] flags_q
);
    typedef struct packed {
        logic [DATA_W-1:0] flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.flags = '0;
        end
        if (fire) begin
            st_d.flags[STAT_IRQ_BIT] = 1'b1;
            st_d.flags[STAT_PER_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;
endmodule

// File: rtl/perirq_gen.sv
module perirq_gen
    import perirq_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              ctl_wr,
    input  logic              ctl_sel,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] stat_rdata,
    output logic              irq_o
);
    localparam int CODE_W = RATE_W;

    logic [CODE_W-1:0] code_q;
    logic              en_q;
    logic              rate_active;
    logic [CNT_W-1:0]  rate_mask;
    logic              fire;
    logic [DATA_W-1:0] flags_q;

    perirq_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .sel    (ctl_sel),
        .wdata  (ctl_wdata),
        .code_q (code_q),
        .en_q   (en_q)
    );

    perirq_rate_dec #(.CNT_W(CNT_W)) u_dec (
        .code   (code_q),
        .active (rate_active),
        .mask   (rate_mask)
    );

    perirq_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .arm       (rate_active & en_q),
        .mask      (rate_mask),
        .fire      (fire)
    );

    perirq_status #(.DATA_W(DATA_W)) u_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .rd      (stat_rd),
        .flags_q (flags_q)
    );

    assign stat_rdata = flags_q;
    assign irq_o      = flags_q[STAT_IRQ_BIT];
endmodule

// File: rtl/perirq_chk.sv
module perirq_chk #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              base_tick,
    input logic              stat_rd,
    input logic [DATA_W-1:0] stat_rdata,
    input logic              irq_o,
    input logic              fire,
    input logic [CODE_W-1:0] code_q,
    input logic              en_q
);
    localparam logic [DATA_W-1:0] SET_FLAGS = DATA_W'(8'hC0);

    a_r2_fire_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> base_tick);

    a_r5_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0) |-> !fire);

    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !fire);

    a_r7_tick_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (stat_rdata == SET_FLAGS) && irq_o);

    a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_rdata != '0) && !stat_rd) |=> (stat_rdata == SET_FLAGS));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !fire) |=> (stat_rdata == '0) && !irq_o);

    a_r9_tick_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && fire) |=> irq_o);
endmodule

bind perirq_gen perirq_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_tick  (base_tick),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .irq_o      (irq_o),
    .fire       (fire),
    .code_q     (code_q),
    .en_q       (en_q)
);

// File: tb/perirq_gen_tb.sv
module perirq_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_N = 8;
    localparam int VEC_CODE [VEC_N] = '{3, 4, 6, 1, 2, 7, 9, 10};
    localparam int VEC_PER  [VEC_N] = '{4, 8, 32, 128, 256, 64, 256, 512};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_sel = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    int model_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perirq_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_tick  (base_tick),
        .ctl_wr     (ctl_wr),
        .ctl_sel    (ctl_sel),
        .ctl_wdata  (ctl_wdata),
        .stat_rd    (stat_rd),
        .stat_rdata (stat_rdata),
        .irq_o      (irq_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk);
        base_tick = 1'b1;
        @(negedge clk);
        base_tick = 1'b0;
        model_cnt++;
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_sel = sel;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic read_stat(output logic [7:0] v);
        @(negedge clk);
        stat_rd = 1'b1;
        v = stat_rdata;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    // strobes n times, predicts each tick from the bench's own count,
    // clears the flags after every observed tick
    task automatic run_ticks(input int n, input int per,
                             output int mism, output int fires, output int expf);
        logic [7:0] junk;
        bit exp_hit;
        mism = 0;
        fires = 0;
        expf = 0;
        for (int i = 0; i < n; i++) begin
            do_tick();
            exp_hit = (per != 0) && ((model_cnt % per) == 0);
            if (exp_hit) expf++;
            if (irq_o) fires++;
            if (irq_o !== exp_hit) mism++;
            if (irq_o) begin
                if (stat_rdata !== 8'hC0) mism++;
                read_stat(junk);
            end
        end
    endtask

    task automatic align(input int per, input int m, input int r);
        int mi, fi, ef;
        while ((model_cnt % m) != r) run_ticks(1, per, mi, fi, ef);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int mi, fi, ef;
        logic [7:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(irq_o == 1'b0, "R1", "irq after reset", int'(irq_o), 0);
        check(stat_rdata == 8'h00, "R1", "status after reset", int'(stat_rdata), 0);

        // R2, R3, R4, R10: rate table walked on a never-reset count
        for (int k = 0; k < VEC_N; k++) begin
            write_reg(1'b0, 8'(VEC_CODE[k]));
            write_reg(1'b1, 8'h40);
            read_stat(v);
            run_ticks(2 * VEC_PER[k] + 7, VEC_PER[k], mi, fi, ef);
            check(mi == 0 && fi == ef && ef > 0,
                  (VEC_CODE[k] <= 2) ? "R4" : "R3",
                  $sformatf("R2 R10 code %0d aligned ticks (mismatches %0d)", VEC_CODE[k], mi),
                  fi, ef);
        end

        // R5: code 0 never ticks
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'h40);
        run_ticks(300, 0, mi, fi, ef);
        check(fi == 0, "R5", "ticks with code 0", fi, 0);

        // R6: enable only at bit 6; R3: upper rate bits ignored
        write_reg(1'b0, 8'hF3);
        write_reg(1'b1, 8'hBF);
        run_ticks(12, 0, mi, fi, ef);
        check(fi == 0, "R6", "ticks with bit 6 clear", fi, 0);
        write_reg(1'b1, 8'h40);
        run_ticks(12, 4, mi, fi, ef);
        check(mi == 0 && fi == ef, "R3", "upper rate bits ignored", fi, ef);

        // R6: multiple reached while disabled is dropped
        align(4, 4, 3);
        write_reg(1'b1, 8'h00);
        do_tick();
        check(irq_o == 1'b0 && stat_rdata == 8'h00, "R6", "boundary while disabled",
              int'(stat_rdata), 0);
        write_reg(1'b1, 8'h40);
        check(stat_rdata == 8'h00, "R6", "no late flag on re-enable", int'(stat_rdata), 0);
        run_ticks(8, 4, mi, fi, ef);
        check(mi == 0 && fi == 2, "R6", "ticks after re-enable", fi, 2);

        // R7: flags set and sticky
        align(4, 4, 3);
        do_tick();
        check(stat_rdata == 8'hC0 && irq_o, "R7", "flags on tick", int'(stat_rdata), 8'hC0);
        for (int i = 0; i < 6; i++) do_tick();
        check(stat_rdata == 8'hC0 && irq_o, "R7", "flags held without read",
              int'(stat_rdata), 8'hC0);

        // R8: read returns value then clears
        read_stat(v);
        check(v == 8'hC0, "R8", "value seen during read", int'(v), 8'hC0);
        check(stat_rdata == 8'h00 && !irq_o, "R8", "status after read",
              int'(stat_rdata), 0);

        // R9: tick and read on the same edge
        align(4, 4, 3);
        do_tick();
        for (int i = 0; i < 3; i++) do_tick();
        @(negedge clk);
        base_tick = 1'b1;
        stat_rd = 1'b1;
        @(negedge clk);
        base_tick = 1'b0;
        stat_rd = 1'b0;
        model_cnt++;
        check(stat_rdata == 8'hC0 && irq_o, "R9", "tick wins over read",
              int'(stat_rdata), 8'hC0);
        read_stat(v);

        // R10: switch to a longer period mid-run
        align(4, 16, 5);
        write_reg(1'b0, 8'h05);
        run_ticks(20, 16, mi, fi, ef);
        check(mi == 0 && fi == 1, "R10", "first tick at next multiple of 16", fi, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule